// File: doc/BRIEF.md
# Multi-channel coarse and fine clock phase selector

This block is the digital half of a clock phase shifter. It runs on a fast clock at 32 times the reference rate. A shared 5-bit counter wraps once per reference period. From that counter each channel builds a square wave at 1x, 2x or 4x the reference rate. The wave is shifted by a whole number of fast-clock periods.

Each channel then selects one of 16 ideal delay taps, each a further 1/16 of a fast period later. The step size is therefore the same at every output rate. The coarse range spans one full reference period at the 1x rate.

Settings are sampled only as the counter wraps, so reprogramming a channel never produces a runt pulse. The analog delay line is outside the block: its taps arrive on `taps_i`, and the selected tap leaves on `clk_o`.

Top module: `psh_top`

## Requirements
- R1: After reset is released the shared counter starts at 0 and advances by one on every fast clock, wrapping from 31 to 0, so the outputs of every channel repeat with a period of 32 cycles or a divisor of it.
- R2: Frequency code 0 gives an output period of N=32 fast cycles, code 1 gives N=16, and codes 2 and 3 both give N=8; every output has a 50 % duty cycle.
- R3: With counter value c and coarse offset k, `coarse_o` of a channel is high exactly while (c - k) mod N < N/2, so it rises when c ≡ k (mod N).
- R4: For N=16 only the low 4 bits of the coarse offset matter, and for N=8 only the low 3 bits.
- R5: New frequency, coarse or fine settings take effect only at the clock edge on which the counter goes from 31 to 0, using the values present at that edge. Changes at any other time have no effect on any output until then.
- R6: The phase code of a channel is 9 bits: bits [8:4] hold the coarse offset and bits [3:0] the fine tap. `fine_sel_o` shows the fine tap currently in effect.
- R7: `clk_o` of channel ch equals `taps_i[16*ch + fine]`, where fine is the fine tap in effect, with no clock delay.
- R8: While reset is asserted the counter is 0 and the settings in effect are all zero, so `coarse_o` is high and `fine_sel_o` is 0.
- R9: The three channels take their settings independently and share only the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, 32x reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_freq_i | input | 6 | Per-channel frequency code, 2 bits per channel, channel 0 lowest |
| cfg_phase_i | input | 27 | Per-channel phase code, 9 bits per channel: [8:4] coarse, [3:0] fine |
| taps_i | input | 48 | Ideal delay-line taps, 16 per channel, channel 0 lowest |
| coarse_o | output | 3 | Coarse-shifted divided clock per channel |
| fine_sel_o | output | 12 | Fine tap in effect, 4 bits per channel |
| clk_o | output | 3 | Selected fine-phase clock per channel |

## Verification
The counter, the settings and `coarse_o` are each one register deep. After any fast-clock edge, `coarse_o` and `fine_sel_o` therefore reflect the counter value and the settings just loaded. A settings change becomes visible on the edge that follows counter value 31, and `clk_o` follows `taps_i` within the same cycle.

The bench drives every input at the falling edge. It advances a behavioural counter and settings model at each rising edge, and compares all outputs at the next falling edge, with new tap values applied only after that comparison. Settings are changed mid-period and more than once per period, to show that only the value present at the wrap counts.

// File: rtl/psh_pkg.sv
package psh_pkg;
  localparam int CNT_W  = 5;
  localparam int FINE_W = 4;
  localparam int PH_W   = CNT_W + FINE_W;

  localparam logic [1:0] FREQ_X1 = 2'd0;
  localparam logic [1:0] FREQ_X2 = 2'd1;

  typedef struct packed {
    logic [1:0]        freq;
    logic [CNT_W-1:0]  coarse;
    logic [FINE_W-1:0] fine;
  } psh_cfg_t;

  function automatic int unsigned period_shift(input logic [1:0] f);
    case (f)
      FREQ_X1: return 0;
      FREQ_X2: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] period_mask(input logic [1:0] f);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> period_shift(f);
  endfunction

  // position within output period, used by checkers
  function automatic logic [CNT_W-1:0] phase_pos(input logic [CNT_W-1:0] cnt,
                                                 input logic [CNT_W-1:0] off,
                                                 input logic [1:0] f);
    logic [CNT_W-1:0] d;
    d = cnt - off;
    return d & period_mask(f);
  endfunction

  function automatic logic [CNT_W-1:0] half_period(input logic [1:0] f);
    return (period_mask(f) >> 1) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/psh_counter.sv
module psh_counter #(
  parameter int CNT_W = psh_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  assign wrap_o    = &cnt_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  // R1
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/psh_chan.sv
module psh_chan
  import psh_pkg::*;
#(
  parameter int CW = psh_pkg::CNT_W,
  parameter int FW = psh_pkg::FINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          wrap_i,
  input  psh_cfg_t      cfg_i,
  output logic          coarse_o,
  output logic [FW-1:0] fine_sel_o
);
  psh_cfg_t act_q, act_nxt;
  logic [CW-1:0] diff_nxt;
  logic          coarse_q, coarse_nxt;
  int unsigned   hi_idx;

  always_comb begin
    act_nxt    = wrap_i ? cfg_i : act_q;
    diff_nxt   = cnt_nxt_i - act_nxt.coarse;
    hi_idx     = CW - 1 - period_shift(act_nxt.freq);
    coarse_nxt = ~diff_nxt[hi_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      coarse_q <= 1'b1;
    end else begin
      act_q    <= act_nxt;
      coarse_q <= coarse_nxt;
    end
  end

  assign coarse_o   = coarse_q;
  assign fine_sel_o = act_q.fine;

  // R5
  a_r5_hold_between_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));

  // R3
  a_r3_rise_at_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(coarse_q) && !$past(wrap_i)) |->
      (phase_pos(cnt_i, act_q.coarse, act_q.freq) == '0));

  // R2
  a_r2_fall_at_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(coarse_q) && !$past(wrap_i)) |->
      (phase_pos(cnt_i, act_q.coarse, act_q.freq) == half_period(act_q.freq)));
endmodule

// File: rtl/psh_tap_mux.sv
module psh_tap_mux #(
  parameter int FW = psh_pkg::FINE_W,
  localparam int NT = 2 ** FW
) (
  input  logic [NT-1:0] taps_i,
  input  logic [FW-1:0] sel_i,
  output logic          clk_o
);
  assign clk_o = taps_i[sel_i];
endmodule

// File: rtl/psh_top.sv
module psh_top
  import psh_pkg::*;
#(
  parameter int NCH = 3,
  localparam int NT = 2 ** FINE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NCH-1:0]      cfg_freq_i,
  input  logic [PH_W*NCH-1:0]   cfg_phase_i,
  input  logic [NT*NCH-1:0]     taps_i,
  output logic [NCH-1:0]        coarse_o,
  output logic [FINE_W*NCH-1:0] fine_sel_o,
  output logic [NCH-1:0]        clk_o
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wrap;

  psh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    psh_cfg_t          cfg;
    logic [FINE_W-1:0] sel;

    assign cfg.freq   = cfg_freq_i[2*ch +: 2];
    assign cfg.coarse = cfg_phase_i[PH_W*ch + FINE_W +: CNT_W];
    assign cfg.fine   = cfg_phase_i[PH_W*ch +: FINE_W];

    psh_chan #(.CW(CNT_W), .FW(FINE_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .cnt_nxt_i  (cnt_nxt),
      .wrap_i     (wrap),
      .cfg_i      (cfg),
      .coarse_o   (coarse_o[ch]),
      .fine_sel_o (sel)
    );

    psh_tap_mux #(.FW(FINE_W)) u_mux (
      .taps_i (taps_i[NT*ch +: NT]),
      .sel_i  (sel),
      .clk_o  (clk_o[ch])
    );

    assign fine_sel_o[FINE_W*ch +: FINE_W] = sel;
  end
endmodule

// File: tb/psh_top_tb.sv
`timescale 1ns/1ps
module psh_top_tb;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_freq = '0;
  logic [26:0] cfg_phase = '0;
  logic [47:0] taps = '0;
  logic [2:0]  coarse, clk_out;
  logic [11:0] fine_sel;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_cnt = 0;
  int a_freq[NCH], a_off[NCH], a_fine[NCH];
  string tag = "R3";

  always #2.5 clk = ~clk;

  psh_top #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_freq_i(cfg_freq), .cfg_phase_i(cfg_phase),
    .taps_i(taps), .coarse_o(coarse), .fine_sel_o(fine_sel), .clk_o(clk_out)
  );

  task automatic chk(input string req, input int act, input int exp, input int ch);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d cnt=%0d actual=%0d expected=%0d", req, ch, m_cnt, act, exp);
    end
  endtask

  function automatic int exp_coarse(input int ch);
    int n, d;
    n = (a_freq[ch] == 0) ? 32 : (a_freq[ch] == 1) ? 16 : 8;
    d = (m_cnt - (a_off[ch] % n) + 32) % n;
    return (d < n/2) ? 1 : 0;
  endfunction

  task automatic compare_all();
    for (int ch = 0; ch < NCH; ch++) begin
      chk(tag, int'(coarse[ch]), exp_coarse(ch), ch);
      chk("R6", int'(fine_sel[4*ch +: 4]), a_fine[ch], ch);
      chk("R7", int'(clk_out[ch]), int'(taps[16*ch + a_fine[ch]]), ch);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (m_cnt == 31)
      for (int ch = 0; ch < NCH; ch++) begin
        a_freq[ch] = cfg_freq[2*ch +: 2];
        a_off[ch]  = cfg_phase[9*ch + 4 +: 5];
        a_fine[ch] = cfg_phase[9*ch +: 4];
      end
    m_cnt = (m_cnt + 1) % 32;
    @(negedge clk);
    compare_all();
    taps = {$urandom(), $urandom()};
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_to(input int c);
    while (m_cnt != c) tick();
  endtask

  task automatic set_ch(input int ch, input int f, input int off, input int fine);
    cfg_freq[2*ch +: 2]  = 2'(f);
    cfg_phase[9*ch +: 9] = {5'(off), 4'(fine)};
  endtask

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin a_freq[ch] = 0; a_off[ch] = 0; a_fine[ch] = 0; end
    set_ch(0, 1, 7, 9);
    repeat (3) @(negedge clk);
    taps = {$urandom(), $urandom()};
    #0.5;
    tag = "R8";
    compare_all();                  // R8: reset state, settings ignored during reset
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    run(40);                        // R1: counter from 0, defaults
    // R9: independent channels
    tag = "R3";
    set_ch(0, 0, 5, 3);
    set_ch(1, 1, 5, 9);
    set_ch(2, 2, 5, 15);
    run(70);
    // R4: high offset bits ignored at 2x and 4x
    tag = "R4";
    set_ch(1, 1, 21, 2);
    set_ch(2, 2, 29, 6);
    run(70);
    // R2: code 3 equals 4x, other rates
    tag = "R2";
    set_ch(0, 3, 0, 1);
    set_ch(1, 0, 31, 14);
    set_ch(2, 1, 15, 0);
    run(70);
    // R5: mid-period change, then several changes before wrap
    tag = "R5";
    run_to(10);
    set_ch(0, 1, 3, 4);
    run(5);
    set_ch(0, 2, 6, 11);
    set_ch(1, 2, 2, 5);
    run_to(30);
    set_ch(0, 0, 17, 8);
    run(60);
    run_to(31);
    set_ch(2, 0, 25, 12);          // present at the wrap edge itself
    run(70);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule